// File: doc/BRIEF.md
# I2C Target Address-Match Responder

This block is the bus-target half of a two-wire serial controller. It watches the clock and data lines, which pass through synchronizers and a glitch filter. It recognises START and STOP conditions and shifts in the first byte after every START. It compares the upper seven bits of that byte with a programmable own address. On a hit it acknowledges the byte, raises sticky flags for software, reports whether the remote controller wants to read or write, and holds the clock line low. The clock is released only when software asks for the next byte.

Software services the block through plain control and status ports. These are a one-cycle `byte_go` strobe, an acknowledge-select bit, a transmit byte, a received byte, a flag vector with write-one-to-clear, and an own-address write port. Both bus lines are open-drain: the block only ever pulls a line low. While the local controller drives the clock as a bus controller (`scl_drive_en` high), the responder stays idle and releases both lines.

Top module: `i2c_target_responder`

## Requirements
- R1: After reset the own address reads 0x01, all five flags are 0, `dir_tx` is 0 and neither line is pulled low.
- R2: A START followed by a byte whose bits [7:1] equal the own address is acknowledged (SDA pulled low in the ninth clock). Flag bit 0 (address hit) is set, and `dir_tx` takes bit 0 of the byte (1 = the remote reads, the target transmits).
- R3: A byte after START that matches neither the own address nor an enabled general call is not acknowledged. It sets no flag and causes no clock hold, and the block ignores the bus until the next START.
- R4: Address 0 is accepted and sets flag bit 1 (general call) together with the hit flag while `gc_disable` is 0. With `gc_disable` at 1, address 0 behaves as a non-matching address.
- R5: After an accepted address, and after every data byte, SCL is held low until software pulses `byte_go`. The block changes SDA only while SCL is low.
- R6: In target-receive, each byte appears on `rx_data` (MSB first on the wire) and sets flag bit 4. It is then acknowledged if `ack_nak` is 0 when `byte_go` is pulsed, or not acknowledged if it is 1.
- R7: In target-transmit, `tx_data` captured at `byte_go` is sent MSB first. An accepted read address and every byte the remote acknowledges set flag bit 3 (transmit empty) and hold the clock.
- R8: When the remote does not acknowledge a transmitted byte, the block releases SDA, requests no further byte (flag bit 3 stays clear) and waits for STOP.
- R9: A STOP (SDA rising while SCL is high) sets flag bit 2 only if it ends a transaction whose address was accepted.
- R10: Flags are sticky and are cleared by writing 1 to the matching bit of `flag_clr`. When a flag is set and cleared in the same cycle, the set wins.
- R11: While `scl_drive_en` is 1 the block releases both lines within one cycle, accepts no address and sets no flag.
- R12: Each accepted address produces a one-cycle `cancel_req` pulse, so that any pending local start or stop request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the clock line |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low |
| scl_drive_en | input | 1 | Local controller owns the clock; target disabled |
| gc_disable | input | 1 | Ignore the general-call address |
| addr_we | input | 1 | Load `addr_wdata` into the own address |
| addr_wdata | input | 7 | New own address |
| own_addr | output | 7 | Current own address |
| byte_go | input | 1 | One-cycle strobe: release the held clock |
| ack_nak | input | 1 | 0 acknowledge, 1 refuse the received byte |
| tx_data | input | 8 | Byte to transmit, captured at `byte_go` |
| rx_data | output | 8 | Last received byte |
| dir_tx | output | 1 | 1 when the accepted transaction is a read |
| flag_clr | input | 5 | Write-one-to-clear for `flags` |
| flags | output | 5 | [0] hit, [1] general call, [2] stop, [3] tx empty, [4] rx full |
| cancel_req | output | 1 | Pulse on each accepted address |

## Verification
A hardware flag set and a software clear can land on the same flag in the same cycle. This is most exposed for the stop flag, which is raised a few filter cycles after SDA rises. The bench ends an addressed write many times. Each time it sends a one-cycle clear of the stop flag shifted by one more cycle after the SDA release. Across the sweep, the flag must survive every early or coincident clear, be removed by every later one, and change its outcome exactly once.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int FLAG_W = 5;

    localparam int FL_HIT  = 0;
    localparam int FL_GC   = 1;
    localparam int FL_STOP = 2;
    localparam int FL_TXE  = 3;
    localparam int FL_RXF  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD_A,
        ST_ACK_A,
        ST_RX,
        ST_HOLD_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD_TX,
        ST_WAIT_STOP
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          filt;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d = q;
        d.sync = {q.sync[0], line_i};
        if (q.sync[1] != q.filt) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.filt = q.sync[1];
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.cnt  <= '0;
            q.filt <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.filt;
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
    import i2c_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl = scl_f;
        d.sda = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ev.start = scl_f & q.scl & q.sda & ~sda_f;
        ev.stop  = scl_f & q.scl & ~q.sda & sda_f;
        ev.rise  = scl_f & ~q.scl;
        ev.fall  = ~scl_f & q.scl;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic              tgt_off,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_dis,
    input  logic              byte_go,
    input  logic              ack_nak,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              dir_tx,
    output logic [FLAG_W-1:0] evs,
    output logic              hit
);
    typedef struct packed {
        tgt_state_e        st;
        logic [BYTE_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              sda_oe;
        logic              scl_oe;
        logic              dir;
        logic              inxfer;
        logic              nak;
        logic [BYTE_W-1:0] rx;
    } fsm_t;

    fsm_t q, d;
    logic is_gc, addr_ok;

    assign is_gc   = (q.sr[BYTE_W-1:1] == '0);
    assign addr_ok = (q.sr[BYTE_W-1:1] == own_addr) || (is_gc && !gc_dis);

    always_comb begin
        d   = q;
        evs = '0;
        hit = 1'b0;
        if (tgt_off) begin
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
            d.inxfer = 1'b0;
        end else if (ev.stop) begin
            evs[FL_STOP] = q.inxfer;
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
            d.inxfer = 1'b0;
        end else if (ev.start) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
            d.scl_oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (ev.rise && q.cnt < CNT_W'(BYTE_W)) begin
                        d.sr  = {q.sr[BYTE_W-2:0], sda_f};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (ev.fall && q.cnt == CNT_W'(BYTE_W)) begin
                        if (addr_ok) begin
                            hit          = 1'b1;
                            evs[FL_HIT]  = 1'b1;
                            evs[FL_GC]   = is_gc;
                            evs[FL_TXE]  = q.sr[0];
                            d.dir        = q.sr[0];
                            d.inxfer     = 1'b1;
                            d.sda_oe     = 1'b1;
                            d.scl_oe     = 1'b1;
                            d.st         = ST_HOLD_A;
                        end else begin
                            d.inxfer = 1'b0;
                            d.st     = ST_WAIT_STOP;
                        end
                    end
                end
                ST_HOLD_A: begin
                    if (byte_go) begin
                        d.sr     = tx_byte;
                        d.scl_oe = 1'b0;
                        d.st     = ST_ACK_A;
                    end
                end
                ST_ACK_A: begin
                    if (ev.fall) begin
                        d.cnt = '0;
                        if (q.dir) begin
                            d.sda_oe = ~q.sr[BYTE_W-1];
                            d.st     = ST_TX;
                        end else begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (ev.rise && q.cnt < CNT_W'(BYTE_W)) begin
                        d.sr  = {q.sr[BYTE_W-2:0], sda_f};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (ev.fall && q.cnt == CNT_W'(BYTE_W)) begin
                        d.rx        = q.sr;
                        evs[FL_RXF] = 1'b1;
                        d.scl_oe    = 1'b1;
                        d.st        = ST_HOLD_RX;
                    end
                end
                ST_HOLD_RX: begin
                    if (byte_go) begin
                        d.sda_oe = ~ack_nak;
                        d.scl_oe = 1'b0;
                        d.st     = ST_RX_ACK;
                    end
                end
                ST_RX_ACK: begin
                    if (ev.fall) begin
                        d.sda_oe = 1'b0;
                        d.cnt    = '0;
                        d.st     = ST_RX;
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_TX_ACK;
                        end else begin
                            d.cnt    = q.cnt + CNT_W'(1);
                            d.sr     = {q.sr[BYTE_W-2:0], 1'b0};
                            d.sda_oe = ~q.sr[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.rise) begin
                        d.nak = sda_f;
                    end else if (ev.fall) begin
                        if (q.nak) begin
                            d.st = ST_WAIT_STOP;
                        end else begin
                            evs[FL_TXE] = 1'b1;
                            d.scl_oe    = 1'b1;
                            d.st        = ST_HOLD_TX;
                        end
                    end
                end
                ST_HOLD_TX: begin
                    if (byte_go) begin
                        d.sr     = tx_byte;
                        d.sda_oe = ~tx_byte[BYTE_W-1];
                        d.cnt    = '0;
                        d.scl_oe = 1'b0;
                        d.st     = ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sr: '0, cnt: '0, sda_oe: 1'b0, scl_oe: 1'b0,
                   dir: 1'b0, inxfer: 1'b0, nak: 1'b0, rx: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.sda_oe;
    assign scl_oe  = q.scl_oe;
    assign rx_byte = q.rx;
    assign dir_tx  = q.dir;

    // SDA may only move while SCL is low, otherwise a false START/STOP results
    assert_sda_low_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(tgt_off) && !$past(ev.start) && !$past(ev.stop))
        |-> $stable(q.sda_oe));

    // a clock hold only ever starts on a line that is already low
    assert_stretch_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.scl_oe) |-> !scl_f);

    assert_off_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_off |=> (!q.sda_oe && !q.scl_oe));
endmodule

// File: rtl/i2c_target_responder.sv
module i2c_target_responder
    import i2c_tgt_pkg::*;
#(
    parameter int               FILT_LEN   = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 7'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              scl_drive_en,
    input  logic              gc_disable,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    output logic [ADDR_W-1:0] own_addr,
    input  logic              byte_go,
    input  logic              ack_nak,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] rx_data,
    output logic              dir_tx,
    input  logic [FLAG_W-1:0] flag_clr,
    output logic [FLAG_W-1:0] flags,
    output logic              cancel_req
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw, filt;
    bus_ev_t           ev;
    logic [FLAG_W-1:0] fsm_ev;
    logic              fsm_hit;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_tgt_filt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw[g]),
            .line_o(filt[g])
        );
    end

    i2c_tgt_cond u_cond (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(filt[0]),
        .sda_f(filt[1]),
        .ev   (ev)
    );

    i2c_tgt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .scl_f   (filt[0]),
        .sda_f   (filt[1]),
        .tgt_off (scl_drive_en),
        .own_addr(own_addr),
        .gc_dis  (gc_disable),
        .byte_go (byte_go),
        .ack_nak (ack_nak),
        .tx_byte (tx_data),
        .sda_oe  (sda_oe),
        .scl_oe  (scl_oe),
        .rx_byte (rx_data),
        .dir_tx  (dir_tx),
        .evs     (fsm_ev),
        .hit     (fsm_hit)
    );

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [ADDR_W-1:0] addr;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d       = q;
        d.flags = (q.flags & ~flag_clr) | fsm_ev;
        if (addr_we) begin
            d.addr = addr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{flags: '0, addr: RESET_ADDR};
        end else begin
            q <= d;
        end
    end

    assign flags      = q.flags;
    assign own_addr   = q.addr;
    assign cancel_req = fsm_hit;

    assert_cancel_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_req |=> q.flags[FL_HIT]);

    assert_gc_with_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flags[FL_GC]) |-> q.flags[FL_HIT]);

    assert_clear_takes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_clr & ~fsm_ev)) |=> ((q.flags & $past(flag_clr & ~fsm_ev)) == '0));
endmodule

// File: tb/tb_i2c_target_responder.sv
module tb_i2c_target_responder;
    localparam int Q        = 16;
    localparam int FW_DELAY = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       m_scl_low, m_sda_low;
    logic       scl_oe, sda_oe;
    logic       scl_drive_en, gc_disable, addr_we;
    logic [6:0] addr_wdata, own_addr;
    logic       fw_go, fw_ack_nak;
    logic [7:0] fw_tx, rx_data;
    logic       dir_tx, cancel_req;
    logic [4:0] fw_clr, tb_clr, flags;

    wire scl_line = !(m_scl_low || scl_oe);
    wire sda_line = !(m_sda_low || sda_oe);

    i2c_target_responder dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_drive_en(scl_drive_en),
        .gc_disable(gc_disable), .addr_we(addr_we), .addr_wdata(addr_wdata),
        .own_addr(own_addr), .byte_go(fw_go), .ack_nak(fw_ack_nak),
        .tx_data(fw_tx), .rx_data(rx_data), .dir_tx(dir_tx),
        .flag_clr(fw_clr | tb_clr), .flags(flags), .cancel_req(cancel_req)
    );

    int nchk = 0, nfail = 0, n_cancel = 0, max_stretch = 0;
    int fw_holds = 0, rx_n = 0, tx_n = 0, fw_nak_at = -1;
    logic [4:0] fw_snap_a;
    logic       fw_dir_a;
    logic [7:0] rx_log [8];
    bit done = 0;

    function automatic logic [7:0] tx_pat(int i);
        return 8'(i * 37 + 5);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) if (rst_n && cancel_req) n_cancel++;

    // ---------------- bus controller model ----------------
    task automatic scl_up();
        int s = 0;
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line) begin s++; @(negedge clk); end
        if (s > max_stretch) max_stretch = s;
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0; wait_n(Q);
        m_sda_low = 1'b1; wait_n(Q);
        m_scl_low = 1'b1; wait_n(2);
    endtask

    task automatic m_wbit(logic b);
        m_sda_low = !b; wait_n(Q);
        scl_up(); wait_n(Q);
        m_scl_low = 1'b1; wait_n(2);
    endtask

    task automatic m_rbit(output logic b);
        m_sda_low = 1'b0; wait_n(Q);
        scl_up(); wait_n(Q / 2);
        b = sda_line; wait_n(Q / 2);
        m_scl_low = 1'b1; wait_n(2);
    endtask

    task automatic m_stop_pre();
        m_sda_low = 1'b1; wait_n(Q);
        scl_up(); wait_n(Q);
    endtask

    task automatic m_stop();
        m_stop_pre();
        m_sda_low = 1'b0; wait_n(Q);
    endtask

    task automatic wbyte(logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(b);
        ack = !b;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin m_rbit(b); v[i] = b; end
        m_wbit(!ack);
    endtask

    // ---------------- software model ----------------
    initial begin
        fw_go = 1'b0; fw_clr = '0; fw_ack_nak = 1'b0; fw_tx = '0;
        fw_snap_a = '0; fw_dir_a = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && scl_oe) begin
                wait_n(FW_DELAY);
                fw_holds++;
                if (flags[0]) begin fw_snap_a = flags; fw_dir_a = dir_tx; end
                if (flags[4]) begin
                    rx_log[rx_n % 8] = rx_data;
                    rx_n++;
                    fw_ack_nak = (rx_n == fw_nak_at);
                    fw_clr = 5'b10000;
                end else if (flags[3]) begin
                    fw_tx = tx_pat(tx_n);
                    tx_n++;
                    fw_clr = 5'b01011;
                end else begin
                    fw_clr = 5'b00011;
                end
                fw_go = 1'b1;
                @(negedge clk);
                fw_go = 1'b0; fw_clr = '0;
                while (scl_oe) @(negedge clk);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic ack, ack2;
        logic [7:0] v;
        int h0, trans;
        logic res [24];
        rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0;
        scl_drive_en = 1'b0; gc_disable = 1'b0; addr_we = 1'b0; addr_wdata = '0;
        tb_clr = '0;
        wait_n(5);
        chk("R1 own", 32'(own_addr), 32'h01);
        chk("R1 flags", 32'(flags), 0);
        chk("R1 oe", {30'd0, scl_oe, sda_oe}, 0);
        chk("R1 dir", 32'(dir_tx), 0);
        rst_n = 1'b1;
        wait_n(10);

        // sweep of every address against the default own address, general call on
        for (int a = 0; a < 128; a++) begin
            logic expa;
            expa = (a == 1) || (a == 0);
            h0 = fw_holds;
            m_start();
            wbyte({7'(a), 1'b0}, ack);
            chk(a == 0 ? "R4 ack" : (expa ? "R2 ack" : "R3 ack"), 32'(ack), 32'(expa));
            if (ack) begin
                wbyte(8'(a) ^ 8'hA5, ack2);
                chk("R6 ack", 32'(ack2), 1);
            end
            m_stop();
            wait_n(20);
            if (expa) begin
                chk("R6 data", 32'(rx_log[(rx_n - 1) % 8]), 32'(8'(a) ^ 8'hA5));
                chk("R4 gc flag", 32'(fw_snap_a[1]), 32'(a == 0));
                chk("R2 dir", 32'(fw_dir_a), 0);
                chk("R9 stop", 32'(flags[2]), 1);
            end else begin
                chk("R3 flags", 32'(flags), 0);
                chk("R3 holds", 32'(fw_holds - h0), 0);
            end
            tb_clr = 5'h1F; wait_n(1); tb_clr = '0;
        end
        chk("R5 stretch", 32'(max_stretch >= FW_DELAY / 2), 1);
        chk("R12 count", 32'(n_cancel), 2);

        // new own address, general call disabled
        addr_wdata = 7'h5A; addr_we = 1'b1; wait_n(1); addr_we = 1'b0; gc_disable = 1'b1;
        chk("R2 own write", 32'(own_addr), 32'h5A);
        m_start(); wbyte(8'h00, ack); m_stop(); wait_n(20);
        chk("R4 disabled ack", 32'(ack), 0);
        chk("R4 disabled flags", 32'(flags), 0);

        // read of three bytes, last refused by the controller
        tx_n = 0;
        m_start();
        wbyte({7'h5A, 1'b1}, ack);
        chk("R2 read ack", 32'(ack), 1);
        chk("R2 read dir", 32'(fw_dir_a), 1);
        for (int i = 0; i < 3; i++) begin
            rbyte(v, i < 2);
            chk("R7 tx byte", 32'(v), 32'(tx_pat(i)));
        end
        m_stop(); wait_n(20);
        chk("R8 requests", 32'(tx_n), 3);
        chk("R8 txe clear", 32'(flags[3]), 0);
        chk("R9 stop read", 32'(flags[2]), 1);
        tb_clr = 5'h1F; wait_n(1); tb_clr = '0;

        // write with the second byte refused by software
        fw_nak_at = rx_n + 2;
        m_start();
        wbyte({7'h5A, 1'b0}, ack);
        wbyte(8'h11, ack);
        chk("R6 first ack", 32'(ack), 1);
        wbyte(8'h22, ack);
        chk("R6 nak", 32'(ack), 0);
        m_stop(); wait_n(20);
        chk("R6 nak data", 32'(rx_log[(rx_n - 1) % 8]), 32'h22);
        fw_nak_at = -1;
        tb_clr = 5'h1F; wait_n(1); tb_clr = '0;

        // local controller owns the clock
        scl_drive_en = 1'b1; wait_n(2);
        chk("R11 released", {30'd0, scl_oe, sda_oe}, 0);
        m_start(); wbyte({7'h5A, 1'b0}, ack); m_stop(); wait_n(20);
        chk("R11 ack", 32'(ack), 0);
        chk("R11 flags", 32'(flags), 0);
        scl_drive_en = 1'b0; wait_n(5);

        // clear of the stop flag swept across its set cycle
        for (int k = 0; k < 24; k++) begin
            m_start(); wbyte({7'h5A, 1'b0}, ack);
            m_stop_pre();
            m_sda_low = 1'b0;
            wait_n(k);
            tb_clr = 5'b00100; wait_n(1); tb_clr = '0;
            wait_n(30);
            res[k] = flags[2];
            tb_clr = 5'h1F; wait_n(1); tb_clr = '0;
        end
        trans = 0;
        for (int k = 1; k < 24; k++) if (res[k] != res[k - 1]) trans++;
        chk("R10 early clear", 32'(res[0]), 1);
        chk("R10 late clear", 32'(res[23]), 0);
        chk("R10 single edge", 32'(trans), 1);
        chk("R12 total", 32'(n_cancel), 28);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule